// File: doc/BRIEF.md
# Slave-Side Port Arbiter for a Bus Matrix

This block sits in front of one slave of a multi-master bus matrix. Every slave in the matrix gets its own copy, so there is no central arbiter: each copy picks one requesting master, grants it, and steers that master's address, control and write data onto the slave's bus.

Arbitration uses a fixed priority in which master 0 ranks highest. The choice is made from the requests seen in one cycle. The grant and the address/control select take effect one cycle later. The write-data select follows one further cycle after the slave accepts the address, which tracks the pipelined data phase of the bus.

A granted master keeps the slave until the slave signals ready for the transfer in progress. When a free slave sees no request, the next cycle shows an explicit no-port state, and in that state the slave sees an idle transfer.

Top module: `slave_port_arb`

## Requirements
- R1: During reset, and in the first cycle after it, the grant vector is all zero, `s_noport` is 1, `s_trans` is IDLE (2'b00), and `s_addr`, `s_write` and `s_wdata` are zero.
- R2: When several masters request at an arbitration point, the lowest-numbered requesting master receives the grant.
- R3: A request seen at an arbitration point in cycle n produces no grant in cycle n. The grant appears in cycle n+1. From cycle n+1, `s_addr`, `s_trans` and `s_write` follow the granted master's inputs, including any change those inputs make while the grant is held.
- R4: While a master holds the grant and `s_ready` is 0, the grant does not change, whatever the other requests are.
- R5: An arbitration point is any clock edge where `s_noport` is 1 or `s_ready` is 1. At that edge the owner is replaced by the priority winner of the current requests.
- R6: `s_wdata` carries the write data of the master whose address phase was accepted at the previous arbitration point. It is zero when that point had no owner.
- R7: If an arbitration point sees no request, then in the next cycle `s_noport` is 1, the grant is zero, `s_trans` is IDLE, and `s_addr` and `s_write` are zero.
- R8: At most one grant bit is set, and `s_noport` is 1 exactly when no grant bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_req | input | N_MST | Per-master request for this slave |
| m_addr | input | N_MST*ADDR_W | Per-master address, master i in slice i |
| m_trans | input | N_MST*2 | Per-master transfer type (IDLE 2'b00, NONSEQ 2'b10) |
| m_write | input | N_MST | Per-master write flag |
| m_wdata | input | N_MST*DATA_W | Per-master write data, master i in slice i |
| s_ready | input | 1 | Slave has completed the current transfer |
| s_addr | output | ADDR_W | Address driven to the slave |
| s_trans | output | 2 | Transfer type driven to the slave |
| s_write | output | 1 | Write flag driven to the slave |
| s_wdata | output | DATA_W | Write data driven to the slave |
| m_grant | output | N_MST | One-hot grant to the masters |
| s_noport | output | 1 | No master owns the slave this cycle |

## Verification
A re-arbitration and a write-data handover can happen at the same clock edge. At that edge the slave accepts master A's address phase while master B wins the next grant, so in the following cycle the address mux shows B while the data mux still shows A. The bench sets this up by keeping `s_ready` high with several overlapping requests. It then checks the grant, `s_addr` and `s_wdata` in that cycle against two different expected masters. A further case drops every request while the data phase of the last owner is still due, so the no-port state and that owner's write data share a cycle.

// File: rtl/spa_pkg.sv
package spa_pkg;
  typedef enum logic [1:0] {
    XFER_IDLE   = 2'b00,
    XFER_BUSY   = 2'b01,
    XFER_NONSEQ = 2'b10,
    XFER_SEQ    = 2'b11
  } xfer_e;
endpackage

// File: rtl/spa_prio_pick.sv
module spa_prio_pick #(
  parameter int N_MST = 4
) (
  input  logic [N_MST-1:0] req,
  output logic [N_MST-1:0] win_oh,
  output logic             win_valid
);
  // Isolate the lowest set bit: lowest index wins.
  function automatic logic [N_MST-1:0] lowest_set(input logic [N_MST-1:0] r);
    return r & ((~r) + {{(N_MST-1){1'b0}}, 1'b1});
  endfunction

  always_comb begin
    win_oh    = lowest_set(req);
    win_valid = |req;
  end
endmodule

// File: rtl/spa_owner.sv
module spa_owner #(
  parameter int N_MST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [N_MST-1:0] win_oh,
  input  logic             win_valid,
  output logic [N_MST-1:0] own_oh,
  output logic             noport_q,
  output logic [N_MST-1:0] dsel_oh
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_oh   <= '0;
      noport_q <= 1'b1;
      dsel_oh  <= '0;
    end else if (adv) begin
      own_oh   <= win_oh;
      noport_q <= ~win_valid;
      dsel_oh  <= own_oh;
    end
  end
endmodule

// File: rtl/spa_sel_mux.sv
module spa_sel_mux #(
  parameter int N_MST = 4,
  parameter int W     = 32
) (
  input  logic [N_MST-1:0]   sel_oh,
  input  logic [N_MST*W-1:0] din,
  output logic [W-1:0]       dout
);
  logic [W-1:0] masked [N_MST];

  for (genvar i = 0; i < N_MST; i++) begin : g_mask
    assign masked[i] = din[i*W +: W] & {W{sel_oh[i]}};
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i < N_MST; i++) dout = dout | masked[i];
  end
endmodule

// File: rtl/slave_port_arb.sv
module slave_port_arb #(
  parameter int N_MST  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_MST-1:0]        m_req,
  input  logic [N_MST*ADDR_W-1:0] m_addr,
  input  logic [N_MST*2-1:0]      m_trans,
  input  logic [N_MST-1:0]        m_write,
  input  logic [N_MST*DATA_W-1:0] m_wdata,
  input  logic                    s_ready,
  output logic [ADDR_W-1:0]       s_addr,
  output logic [1:0]              s_trans,
  output logic                    s_write,
  output logic [DATA_W-1:0]       s_wdata,
  output logic [N_MST-1:0]        m_grant,
  output logic                    s_noport
);
  localparam int CTL_W = ADDR_W + 3;

  logic [N_MST-1:0]       win_oh;
  logic                   win_valid;
  logic [N_MST-1:0]       own_oh;
  logic [N_MST-1:0]       dsel_oh;
  logic                   noport_q;
  logic                   adv;
  logic [N_MST*CTL_W-1:0] ctl_flat;
  logic [CTL_W-1:0]       ctl_sel;

  // Arbitration point: slave free, or current transfer completing.
  assign adv = noport_q | s_ready;

  spa_prio_pick #(.N_MST(N_MST)) u_pick (
    .req       (m_req),
    .win_oh    (win_oh),
    .win_valid (win_valid)
  );

  spa_owner #(.N_MST(N_MST)) u_owner (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .win_oh    (win_oh),
    .win_valid (win_valid),
    .own_oh    (own_oh),
    .noport_q  (noport_q),
    .dsel_oh   (dsel_oh)
  );

  for (genvar i = 0; i < N_MST; i++) begin : g_pack
    assign ctl_flat[i*CTL_W +: CTL_W] =
      {m_addr[i*ADDR_W +: ADDR_W], m_trans[i*2 +: 2], m_write[i]};
  end

  spa_sel_mux #(.N_MST(N_MST), .W(CTL_W)) u_ctl_mux (
    .sel_oh (own_oh),
    .din    (ctl_flat),
    .dout   (ctl_sel)
  );

  spa_sel_mux #(.N_MST(N_MST), .W(DATA_W)) u_wdata_mux (
    .sel_oh (dsel_oh),
    .din    (m_wdata),
    .dout   (s_wdata)
  );

  assign s_addr   = ctl_sel[CTL_W-1 -: ADDR_W];
  assign s_trans  = ctl_sel[2:1];
  assign s_write  = ctl_sel[0];
  assign m_grant  = own_oh;
  assign s_noport = noport_q;
endmodule

// File: rtl/slave_port_arb_chk.sv
module slave_port_arb_chk #(
  parameter int N_MST = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_MST-1:0] m_req,
  input logic             s_ready,
  input logic [N_MST-1:0] m_grant,
  input logic             s_noport,
  input logic [1:0]       s_trans,
  input logic [N_MST-1:0] dsel_oh,
  input logic             adv
);
  import spa_pkg::*;

  assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_grant));

  assert_noport_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s_noport == (m_grant == '0));

  assert_hold_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_noport && !s_ready) |=> $stable(m_grant));

  assert_top_prio_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && m_req[0]) |=> m_grant[0]);

  assert_grant_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (m_req != '0)) |=> !s_noport);

  assert_idle_when_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s_noport |-> (s_trans == XFER_IDLE));

  assert_data_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !s_noport) |=> (dsel_oh == $past(m_grant)));
endmodule

bind slave_port_arb slave_port_arb_chk #(.N_MST(N_MST)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .m_req    (m_req),
  .s_ready  (s_ready),
  .m_grant  (m_grant),
  .s_noport (s_noport),
  .s_trans  (s_trans),
  .dsel_oh  (dsel_oh),
  .adv      (adv)
);

// File: tb/slave_port_arb_tb.sv
module slave_port_arb_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NV = 15;
  localparam logic [2:0] NONE = 3'd4;

  // {req[3:0], ready, exp_grant[3:0], exp_noport, exp_data_master[2:0]}
  localparam logic [12:0] VEC [NV] = '{
    {4'b0000, 1'b1, 4'b0000, 1'b1, NONE},
    {4'b0110, 1'b0, 4'b0000, 1'b1, NONE},
    {4'b0111, 1'b0, 4'b0010, 1'b0, NONE},
    {4'b0111, 1'b0, 4'b0010, 1'b0, NONE},
    {4'b0101, 1'b1, 4'b0010, 1'b0, NONE},
    {4'b0100, 1'b1, 4'b0001, 1'b0, 3'd1},
    {4'b0000, 1'b1, 4'b0100, 1'b0, 3'd0},
    {4'b1000, 1'b0, 4'b0000, 1'b1, 3'd2},
    {4'b1000, 1'b1, 4'b1000, 1'b0, NONE},
    {4'b1111, 1'b1, 4'b1000, 1'b0, 3'd3},
    {4'b1110, 1'b1, 4'b0001, 1'b0, 3'd3},
    {4'b0000, 1'b0, 4'b0010, 1'b0, 3'd0},
    {4'b0000, 1'b1, 4'b0010, 1'b0, 3'd0},
    {4'b0000, 1'b0, 4'b0000, 1'b1, 3'd1},
    {4'b0000, 1'b0, 4'b0000, 1'b1, NONE}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] m_req = '0;
  logic s_ready = 1'b0;
  logic [N*AW-1:0] m_addr;
  logic [N*2-1:0]  m_trans;
  logic [N-1:0]    m_write;
  logic [N*DW-1:0] m_wdata;
  logic [AW-1:0] s_addr;
  logic [1:0]    s_trans;
  logic          s_write;
  logic [DW-1:0] s_wdata;
  logic [N-1:0]  m_grant;
  logic          s_noport;

  logic [AW-1:0] addr_i [N];
  logic [DW-1:0] wdat_i [N];
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      m_addr[i*AW +: AW]  = addr_i[i];
      m_wdata[i*DW +: DW] = wdat_i[i];
      m_trans[i*2 +: 2]   = m_req[i] ? 2'b10 : 2'b00;
      m_write[i]          = (i % 2) == 1;
    end
  end

  slave_port_arb #(.N_MST(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_addr(m_addr),
    .m_trans(m_trans), .m_write(m_write), .m_wdata(m_wdata),
    .s_ready(s_ready), .s_addr(s_addr), .s_trans(s_trans),
    .s_write(s_write), .s_wdata(s_wdata), .m_grant(m_grant),
    .s_noport(s_noport)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int oh_idx(input logic [N-1:0] oh);
    for (int i = 0; i < N; i++) if (oh[i]) return i;
    return -1;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      addr_i[i] = AW'(16'hA000 + i * 16'h0110);
      wdat_i[i] = 32'hD000_0000 + i * 32'h0101_0101;
    end
    repeat (2) @(posedge clk);
    #1;
    chk("R1 grant in reset", 32'(m_grant), 32'h0);
    chk("R1 noport in reset", 32'(s_noport), 32'h1);
    chk("R1 trans in reset", 32'(s_trans), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [N-1:0] eg;
      logic [2:0]   ed;
      int gi;
      @(negedge clk);
      m_req   = VEC[v][12:9];
      s_ready = VEC[v][8];
      eg = VEC[v][7:4];
      ed = VEC[v][2:0];
      gi = oh_idx(eg);
      #1;
      chk($sformatf("R2/R4/R5 grant vec%0d", v), 32'(m_grant), 32'(eg));
      chk($sformatf("R7/R8 noport vec%0d", v), 32'(s_noport), 32'(VEC[v][3]));
      chk($sformatf("R3/R7 addr vec%0d", v), 32'(s_addr),
          gi < 0 ? 32'h0 : 32'(addr_i[gi]));
      chk($sformatf("R3/R7 trans vec%0d", v), 32'(s_trans),
          gi < 0 ? 32'h0 : (m_req[gi] ? 32'h2 : 32'h0));
      chk($sformatf("R3 write vec%0d", v), 32'(s_write),
          gi < 0 ? 32'h0 : 32'((gi % 2) == 1));
      chk($sformatf("R6 wdata vec%0d", v), s_wdata,
          ed == NONE ? 32'h0 : wdat_i[ed]);
    end

    // Directed: one-cycle overhead and priority from a free slave.
    @(negedge clk);
    m_req = 4'b1100; s_ready = 1'b0;
    #1;
    chk("R3 no grant in request cycle", 32'(m_grant), 32'h0);
    chk("R7 trans idle while free", 32'(s_trans), 32'h0);
    @(negedge clk);
    m_req = 4'b0111;
    #1;
    chk("R2 lowest of two requests", 32'(m_grant), 32'b0100);
    chk("R3 addr of new owner", 32'(s_addr), 32'(addr_i[2]));
    chk("R3 trans of new owner", 32'(s_trans), 32'h2);
    addr_i[2] = 16'h5A5A;
    #1;
    chk("R3 addr follows held owner", 32'(s_addr), 32'h5A5A);
    @(negedge clk);
    #1;
    chk("R4 grant held while busy", 32'(m_grant), 32'b0100);
    s_ready = 1'b1;
    @(negedge clk);
    #1;
    chk("R5 re-arbitrated on ready", 32'(m_grant), 32'b0001);
    chk("R6 data of accepted owner", s_wdata, wdat_i[2]);
    chk("R3 addr switched to winner", 32'(s_addr), 32'(addr_i[0]));

    // Directed: reset while owned.
    rst_n = 1'b0;
    #1;
    chk("R1 grant cleared by reset", 32'(m_grant), 32'h0);
    chk("R1 noport set by reset", 32'(s_noport), 32'h1);
    chk("R1 trans idle in reset", 32'(s_trans), 32'h0);
    chk("R1 wdata zero in reset", s_wdata, 32'h0);
    chk("R1 addr zero in reset", 32'(s_addr), 32'h0);
    @(negedge clk);
    m_req = '0;
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 free after reset", 32'(s_noport), 32'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule